// File: doc/BRIEF.md
# Function-Coded SPI Transfer Engine

This block is the back end of a serial-bus-to-SPI bridge. A front end collects a command byte (the function code) and a run of data bytes into a shared byte buffer. Once a complete message has arrived, it pulses a start strobe and presents the function code and the byte count. When the code lies between 01h and 0Fh, the engine becomes an SPI master. It drives low every select line whose bit is set in the low four bits of the code. It then clocks each buffered byte out in arrival order and writes the byte returned on MISO back over the byte that was just sent. The front end then reads the buffer to collect the slave's reply.

While the engine works it raises a busy flag, which the front end uses to refuse new traffic. Codes outside the SPI range, and a byte count of zero, are dropped without any bus activity.

Top module: `spi_fn_engine`

## Requirements
- R1: A start pulse with a function code from 01h to 0Fh and a nonzero byte count raises `busy_o` in the clock cycle after the strobe.
- R2: During a transfer `ss_n_o[k]` is low exactly when bit k of the function code is 1, for k = 0..3. Several selects may be low together.
- R3: The selected lines go low before the first rising SCLK edge and hold one unchanged value across all bytes, including the gaps between bytes. All lines return high after the last falling SCLK edge.
- R4: SPI mode 0 is used: SCLK idles low, MOSI does not change at a rising edge, MISO is sampled on the rising edge, and the most significant bit goes first. Each SCLK high phase lasts `HALF_DIV` clock cycles.
- R5: The bytes at buffer addresses 0 to count-1 are sent in ascending address order, 8 SCLK pulses per byte.
- R6: The MISO byte captured while byte n is shifted out is written to buffer address n. No address at or above the count is written.
- R7: `busy_o` stays high at every SCLK edge of the transfer and falls in the same cycle that the selects are released.
- R8: Function code 00h, or any code from 10h to FFh, produces no SCLK pulse and no select, and `busy_o` stays low.
- R9: A byte count of zero produces no SCLK pulse and no select, and `busy_o` stays low.
- R10: A byte count above `BUF_DEPTH` (200) is treated as `BUF_DEPTH`.
- R11: While `busy_o` is high, the start strobe, function code and byte count are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request after a complete message |
| func_code_i | input | 8 | Function code of the message |
| byte_cnt_i | input | CNT_W | Number of buffered data bytes |
| busy_o | output | 1 | High while a transfer runs |
| buf_raddr_o | output | ADDR_W | Buffer read address (data returns one cycle later) |
| buf_rdata_i | input | 8 | Buffer read data |
| buf_we_o | output | 1 | Buffer write enable |
| buf_waddr_o | output | ADDR_W | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write data (received MISO byte) |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| ss_n_o | output | 4 | Active-low slave selects |

## Verification
The hardest state to reach is a start request that arrives while a transfer is already running. The front end would never produce it. A second concern is a select mask that must survive the idle gaps between bytes, where SCLK is low and the engine is fetching the next buffer entry. The bench sweeps all 32 codes from 00h to 1Fh, and on every valid transfer it fires a second, different start with a new code and count in the middle of the run. A slave model checks the select vector at every rising edge and counts every change of the vector. Transfers of 200 bytes, and a count of 250, run the index through its widest range and the clamp.

// File: rtl/spi_fn_pkg.sv
`timescale 1ns/1ps
package spi_fn_pkg;

    localparam int SEL_LINES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_SHIFT = 2'd3
    } fn_state_e;

    // True when the code asks for an SPI transfer (select mask nonzero, upper bits clear)
    function automatic logic code_is_spi(input logic [7:0] code);
        return (code[7:SEL_LINES] == '0) && (code[SEL_LINES-1:0] != '0);
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        logic [2:0]       bit_idx;
        logic             sclk;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             done;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.run) begin
            if (load_i) begin
                sh_d.run     = 1'b1;
                sh_d.tx      = byte_i;
                sh_d.div     = '0;
                sh_d.bit_idx = '0;
                sh_d.sclk    = 1'b0;
            end
        end else if (sh_q.div == DIV_LAST) begin
            sh_d.div = '0;
            if (!sh_q.sclk) begin
                sh_d.sclk = 1'b1;
                sh_d.rx   = {sh_q.rx[6:0], miso_i};
            end else begin
                sh_d.sclk = 1'b0;
                if (sh_q.bit_idx == 3'd7) begin
                    sh_d.run  = 1'b0;
                    sh_d.done = 1'b1;
                end else begin
                    sh_d.bit_idx = sh_q.bit_idx + 3'd1;
                    sh_d.tx      = {sh_q.tx[6:0], 1'b0};
                end
            end
        end else begin
            sh_d.div = sh_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk_o = sh_q.sclk;
    assign mosi_o = sh_q.tx[7];
    assign done_o = sh_q.done;
    assign rx_o   = sh_q.rx;

    // R4
    mosi_steady_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_q.sclk) |-> $stable(mosi_o));

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sclk_o);

endmodule

// File: rtl/spi_fn_ctrl.sv
`timescale 1ns/1ps
module spi_fn_ctrl
    import spi_fn_pkg::*;
#(
    parameter int BUF_DEPTH = 200,
    parameter int CNT_W     = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [7:0]           func_code_i,
    input  logic [CNT_W-1:0]     byte_cnt_i,
    output logic                 busy_o,
    output logic [ADDR_W-1:0]    raddr_o,
    input  logic [7:0]           rdata_i,
    output logic                 we_o,
    output logic [ADDR_W-1:0]    waddr_o,
    output logic [7:0]           wdata_o,
    output logic [SEL_LINES-1:0] sel_n_o,
    output logic                 shf_load_o,
    output logic [7:0]           shf_byte_o,
    input  logic                 shf_done_i,
    input  logic [7:0]           shf_rx_i
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BUF_DEPTH);

    typedef struct packed {
        fn_state_e            state;
        logic [SEL_LINES-1:0] mask;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     idx;
        logic [SEL_LINES-1:0] sel_n;
    } ctl_t;

    ctl_t ct_d, ct_q;
    logic             code_ok;
    logic [CNT_W-1:0] cnt_eff;
    logic             last_byte;

    assign code_ok   = code_is_spi(func_code_i);
    assign cnt_eff   = (byte_cnt_i > CNT_MAX) ? CNT_MAX : byte_cnt_i;
    assign last_byte = (ct_q.idx == ct_q.cnt - CNT_W'(1));

    always_comb begin
        ct_d = ct_q;
        unique case (ct_q.state)
            ST_IDLE: begin
                if (start_i && code_ok && (cnt_eff != '0)) begin
                    ct_d.mask  = func_code_i[SEL_LINES-1:0];
                    ct_d.cnt   = cnt_eff;
                    ct_d.idx   = '0;
                    ct_d.sel_n = ~func_code_i[SEL_LINES-1:0];
                    ct_d.state = ST_FETCH;
                end
            end
            ST_FETCH: ct_d.state = ST_LOAD;
            ST_LOAD:  ct_d.state = ST_SHIFT;
            ST_SHIFT: begin
                if (shf_done_i) begin
                    if (last_byte) begin
                        ct_d.state = ST_IDLE;
                        ct_d.sel_n = '1;
                    end else begin
                        ct_d.idx   = ct_q.idx + CNT_W'(1);
                        ct_d.state = ST_FETCH;
                    end
                end
            end
            default: ct_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q       <= '0;
            ct_q.state <= ST_IDLE;
            ct_q.sel_n <= '1;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign busy_o     = (ct_q.state != ST_IDLE);
    assign raddr_o    = ct_q.idx[ADDR_W-1:0];
    assign shf_load_o = (ct_q.state == ST_LOAD);
    assign shf_byte_o = rdata_i;
    assign we_o       = (ct_q.state == ST_SHIFT) && shf_done_i;
    assign waddr_o    = ct_q.idx[ADDR_W-1:0];
    assign wdata_o    = shf_rx_i;
    assign sel_n_o    = ct_q.sel_n;

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.state == ST_IDLE) |-> (sel_n_o == '1));

    // R6
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (ct_q.idx < ct_q.cnt));

    // R11
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ct_q.mask) && $stable(ct_q.cnt)));

    // R8
    reject_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !code_ok) |=> !busy_o);

    // R9
    reject_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (byte_cnt_i == '0)) |=> !busy_o);

endmodule

// File: rtl/spi_fn_engine.sv
`timescale 1ns/1ps
module spi_fn_engine
    import spi_fn_pkg::*;
#(
    parameter int BUF_DEPTH = 200,
    parameter int CNT_W     = 8,
    parameter int HALF_DIV  = 2,
    localparam int ADDR_W   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        func_code_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] buf_raddr_o,
    input  logic [7:0]        buf_rdata_i,
    output logic              buf_we_o,
    output logic [ADDR_W-1:0] buf_waddr_o,
    output logic [7:0]        buf_wdata_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [3:0]        ss_n_o
);
    logic                 shf_load;
    logic [7:0]           shf_byte;
    logic                 shf_done;
    logic [7:0]           shf_rx;
    logic [SEL_LINES-1:0] sel_n;

    spi_fn_ctrl #(
        .BUF_DEPTH (BUF_DEPTH),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .func_code_i (func_code_i),
        .byte_cnt_i  (byte_cnt_i),
        .busy_o      (busy_o),
        .raddr_o     (buf_raddr_o),
        .rdata_i     (buf_rdata_i),
        .we_o        (buf_we_o),
        .waddr_o     (buf_waddr_o),
        .wdata_o     (buf_wdata_o),
        .sel_n_o     (sel_n),
        .shf_load_o  (shf_load),
        .shf_byte_o  (shf_byte),
        .shf_done_i  (shf_done),
        .shf_rx_i    (shf_rx)
    );

    spi_byte_shifter #(
        .HALF_DIV (HALF_DIV)
    ) i_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (shf_load),
        .byte_i (shf_byte),
        .miso_i (miso_i),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .done_o (shf_done),
        .rx_o   (shf_rx)
    );

    for (genvar k = 0; k < SEL_LINES; k++) begin : g_sel
        assign ss_n_o[k] = sel_n[k];
    end

    // R7
    edge_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sclk_o) |-> (busy_o && (ss_n_o != 4'hF)));

    // R3
    sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ss_n_o));

endmodule

// File: tb/test_spi_fn_engine.sv
`timescale 1ns/1ps
module test_spi_fn_engine;
    localparam int DEPTH = 200;
    localparam int DIV   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] code = 8'h00;
    logic [7:0] cnt = 8'h00;
    logic       busy;
    logic [7:0] raddr, waddr, wdata;
    logic [7:0] rdata = 8'h00;
    logic       we, sclk, mosi;
    logic       miso = 1'b0;
    logic [3:0] ss_n;

    always #4 clk = ~clk;

    spi_fn_engine #(.BUF_DEPTH(DEPTH), .CNT_W(8), .HALF_DIV(DIV)) i_spi_fn_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .func_code_i(code),
        .byte_cnt_i(cnt), .busy_o(busy), .buf_raddr_o(raddr),
        .buf_rdata_i(rdata), .buf_we_o(we), .buf_waddr_o(waddr),
        .buf_wdata_o(wdata), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso), .ss_n_o(ss_n)
    );

    logic [7:0] mem  [0:255];
    logic [7:0] orig [0:255];
    logic [7:0] cap  [0:255];

    always @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) mem[waddr] <= wdata;
    end

    int n_cmp = 0, n_bad = 0;
    int rises, nbyte, bitpos, ss_err, busy_err, hp_err, ss_chg, busy_seen;
    logic [3:0] exp_ss;
    logic [7:0] shreg;
    realtime t_rise;

    function automatic logic [7:0] resp(int n);
        return 8'((n * 37 + 8'h5A) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // slave model
    always @(posedge sclk) begin
        shreg = {shreg[6:0], mosi};
        rises++;
        t_rise = $realtime;
        if (ss_n !== exp_ss) ss_err++;
        if (busy !== 1'b1) busy_err++;
        bitpos++;
        if (bitpos == 8) begin
            cap[nbyte[7:0]] = shreg;
            nbyte++;
            bitpos = 0;
        end
    end
    always @(negedge sclk) begin
        if ($realtime - t_rise != DIV * 8.0) hp_err++;
        if (busy !== 1'b1) busy_err++;
        miso = resp(nbyte)[7 - bitpos];
    end
    always @(ss_n) begin
        ss_chg++;
        if (ss_n != 4'hF) miso = resp(0)[7];
    end
    always @(posedge clk) if (busy === 1'b1) busy_seen++;

    task automatic run_case(input logic [7:0] fc, input int bc);
        int eff;
        bit valid;
        valid = (fc >= 8'h01) && (fc <= 8'h0F);
        eff = (bc > DEPTH) ? DEPTH : bc;
        if (!valid) eff = 0;
        for (int i = 0; i < 256; i++) begin
            orig[i] = 8'((i * 13 + fc * 7 + 5) & 8'hFF);
            mem[i]  = orig[i];
            cap[i]  = 8'h00;
        end
        rises = 0; nbyte = 0; bitpos = 0; ss_err = 0; busy_err = 0;
        hp_err = 0; ss_chg = 0; busy_seen = 0; exp_ss = ~fc[3:0];
        @(negedge clk);
        start = 1'b1; code = fc; cnt = 8'(bc);
        @(negedge clk);
        start = 1'b0; code = 8'h00; cnt = 8'h00;
        // R1 busy the cycle after the strobe
        chk(busy === (eff > 0), "R1", busy, eff > 0);
        if (eff > 0) begin
            repeat (12) @(negedge clk);
            // R11 a second request during the run must be ignored
            start = 1'b1; code = ~fc & 8'h0F; cnt = 8'd3;
            @(negedge clk);
            start = 1'b0; code = 8'h00; cnt = 8'h00;
            for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
            chk(!busy, "R7 watchdog", busy, 0);
        end else begin
            repeat (40) @(negedge clk);
            // R8 R9 nothing happens
            chk(busy_seen == 0, "R8/R9 busy", busy_seen, 0);
        end
        repeat (3) @(negedge clk);
        // R5 R4 R9 R10 pulse count
        chk(rises == 8 * eff, "R5 sclk pulses", rises, 8 * eff);
        // R2 R11 mask seen at every edge
        chk(ss_err == 0, "R2 select mask", ss_err, 0);
        // R7
        chk(busy_err == 0, "R7 busy at edges", busy_err, 0);
        // R4
        chk(hp_err == 0, "R4 half period", hp_err, 0);
        // R3 exactly one fall and one release
        chk(ss_chg == ((eff > 0) ? 2 : 0), "R3 select changes", ss_chg, (eff > 0) ? 2 : 0);
        chk(ss_n == 4'hF, "R3 released", ss_n, 15);
        for (int i = 0; i < 256; i++) begin
            if (i < eff) begin
                // R5
                if (cap[i] !== orig[i]) chk(0, "R5 mosi byte", cap[i], orig[i]);
                // R6
                if (mem[i] !== resp(i)) chk(0, "R6 writeback", mem[i], resp(i));
            end else if (mem[i] !== orig[i]) begin
                chk(0, "R6 untouched", mem[i], orig[i]);
            end
        end
        chk(1'b1, "R6 scan", 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && ss_n == 4'hF && sclk == 0, "R3 reset state", {busy, ss_n, sclk}, 8'h1E);
        for (int c = 0; c < 32; c++) run_case(8'(c), 3);
        run_case(8'h05, 0);   // R9
        run_case(8'h05, 1);
        run_case(8'h0A, 2);
        run_case(8'h03, 7);
        run_case(8'h09, 200);
        run_case(8'h0F, 250); // R10
        run_case(8'h81, 4);   // R8
        run_case(8'hFF, 4);   // R8
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule